// File: doc/BRIEF.md
# Dead-Time PWM Timer

This block is a single-channel timer for driving a half-bridge. A 16-bit counter counts up from zero at a rate set by a programmable clock divider, wraps after reaching a programmed period, and an 8-bit repetition count decides how many wraps pass before an update event fires. The one channel compares the count against a programmable threshold. It runs either as a PWM generator or as a toggle-on-match output compare. It drives a main and a complementary output, with a programmable guard interval inserted at every switch between them.

Software programs the block through a simple one-cycle write port and a combinational read port. Divider and repetition values are double-buffered and only take effect at an update event, so a running waveform never sees a torn period. A brake input, OR-ed with a clock-failure flag, forces both outputs at once to programmed safe levels. The outputs stay there until software re-arms them. A one-pulse option stops the counter at its first update event.

Top module: `pwm_dt_timer`

## Requirements
- R1: After reset the run and output-enable bits are 0, both idle levels are 0, so both outputs and update_evt are 0 and the count reads 0.
- R2: While running, the count advances once every DIV+1 clocks, where DIV is the active divider value.
- R3: The count runs 0, 1, ... up to PERIOD; a divided tick that finds the count at or above PERIOD returns it to 0 (a wrap).
- R4: At a wrap with the repetition counter at 0, update_evt is high for exactly one clock (the cycle in which the count first reads 0) and the repetition counter reloads; at other wraps it decrements. Events therefore come every (REP+1)*(PERIOD+1)*(DIV+1) clocks.
- R5: DIV and REP written while running take effect only from the next update event; while stopped, the count, divider phase and repetition counter are held at their start values and the written values apply at once.
- R6: The reference waveform is 0 while stopped. In PWM mode it is high while count < CMP. In compare mode it toggles at each divided tick that finds count == CMP and starts low.
- R7: The outputs follow the reference one clock later. On each reference change both outputs go low for DT divided ticks (counted every clock while stopped), then the main output is high for a high reference and the complementary output is high for a low one.
- R8: brake_in or clk_fail forces out_main and out_comp to the idle levels in the same cycle and clears the output-enable bit at the next edge.
- R9: While the output-enable bit is 0 both outputs sit at the idle levels; after a brake they stay there until software writes the bit to 1 with no brake present.
- R10: In one-pulse mode the run bit is cleared by hardware at the update event, so the count returns to 0 and stays there.
- R11: Register map (address: content): 0 control with bit0 run, bit1 PWM mode (0 = compare toggle), bit2 one-pulse, bit3 output enable, bit4 idle level of out_main, bit5 idle level of out_comp; 1 DIV; 2 PERIOD; 3 REP in bits 7:0; 4 CMP; 5 DT in bits 7:0; 6 count (read only). Reads of 1 and 3 return the written (buffered) values; unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one clock per write |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Combinational read data |
| brake_in | input | 1 | Brake request |
| clk_fail | input | 1 | Clock-failure flag, acts as a brake |
| out_main | output | 1 | Main channel output |
| out_comp | output | 1 | Complementary channel output |
| update_evt | output | 1 | One-clock update event pulse |

## Verification
A write lands at the edge after the strobe. Count, reference state and update_evt change at the following edge, and the gated outputs lag the reference by one more register, while the brake reaches the outputs with no register at all. The bench model steps once per rising edge with the same register counts, and it is compared against the ports on every falling edge. Brake checks are taken a moment after the brake is driven, inside the same cycle. Waveform checks count high cycles over whole periods after a settling interval, so they do not depend on phase.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 3'd0,
        A_DIV    = 3'd1,
        A_PERIOD = 3'd2,
        A_REP    = 3'd3,
        A_CMP    = 3'd4,
        A_DT     = 3'd5,
        A_COUNT  = 3'd6
    } reg_addr_e;

    // bit0 run ... bit5 idle level of complementary output
    typedef struct packed {
        logic idle_comp;
        logic idle_main;
        logic out_en;
        logic one_pulse;
        logic pwm_mode;
        logic run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic gated_out(logic active, logic raw, logic idle);
        return active ? raw : idle;
    endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import pwm_dt_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 16,
    parameter int REP_W  = 8,
    parameter int DT_W   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic                brk,
    input  logic                upd_fire,
    input  logic [CNT_W-1:0]    count,
    output ctrl_t               ctrl,
    output logic [PSC_W-1:0]    div_pre,
    output logic [CNT_W-1:0]    period,
    output logic [REP_W-1:0]    rep_pre,
    output logic [CNT_W-1:0]    cmp,
    output logic [DT_W-1:0]     dt,
    output logic [DATA_W-1:0]   rd_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            div_pre <= '0;
            period  <= '0;
            rep_pre <= '0;
            cmp     <= '0;
            dt      <= '0;
        end else begin
            if (wr_en) begin
                case (wr_addr)
                    A_CTRL:   ctrl    <= ctrl_t'(wr_data[CTRL_W-1:0]);
                    A_DIV:    div_pre <= wr_data[PSC_W-1:0];
                    A_PERIOD: period  <= wr_data[CNT_W-1:0];
                    A_REP:    rep_pre <= wr_data[REP_W-1:0];
                    A_CMP:    cmp     <= wr_data[CNT_W-1:0];
                    A_DT:     dt      <= wr_data[DT_W-1:0];
                    default:  ;
                endcase
            end
            // hardware overrides win over a same-cycle write
            if (brk)
                ctrl.out_en <= 1'b0;
            if (upd_fire && ctrl.one_pulse)
                ctrl.run <= 1'b0;
        end
    end

    always_comb begin
        case (rd_addr)
            A_CTRL:   rd_data = DATA_W'(ctrl);
            A_DIV:    rd_data = DATA_W'(div_pre);
            A_PERIOD: rd_data = DATA_W'(period);
            A_REP:    rd_data = DATA_W'(rep_pre);
            A_CMP:    rd_data = DATA_W'(cmp);
            A_DT:     rd_data = DATA_W'(dt);
            A_COUNT:  rd_data = DATA_W'(count);
            default:  rd_data = '0;
        endcase
    end

    // R10: one-pulse stop at the update event
    a_r10_one_pulse_stop: assert property (@(posedge clk) disable iff (rst)
        (upd_fire && ctrl.one_pulse) |=> !ctrl.run);

    // R8: brake drops the output enable
    a_r8_brake_clears_en: assert property (@(posedge clk) disable iff (rst)
        brk |=> !ctrl.out_en);

endmodule

// File: rtl/tmr_timebase.sv
module tmr_timebase #(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16,
    parameter int REP_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PSC_W-1:0] div_pre,
    input  logic [CNT_W-1:0] period,
    input  logic [REP_W-1:0] rep_pre,
    output logic             tick,
    output logic             upd_fire,
    output logic [CNT_W-1:0] count,
    output logic             update_evt
);

    logic [PSC_W-1:0] div_q;
    logic [PSC_W-1:0] div_act_q;
    logic [CNT_W-1:0] cnt_q;
    logic [REP_W-1:0] rep_q;
    logic             upd_q;
    logic             wrap;

    assign tick     = run && (div_q == div_act_q);
    assign wrap     = tick && (cnt_q >= period);
    assign upd_fire = wrap && (rep_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q     <= '0;
            div_act_q <= '0;
            cnt_q     <= '0;
            rep_q     <= '0;
            upd_q     <= 1'b0;
        end else begin
            upd_q <= upd_fire;
            if (!run) begin
                div_q     <= '0;
                cnt_q     <= '0;
                rep_q     <= rep_pre;
                div_act_q <= div_pre;
            end else if (tick) begin
                div_q <= '0;
                if (wrap) begin
                    cnt_q <= '0;
                    if (rep_q == '0) begin
                        rep_q     <= rep_pre;
                        div_act_q <= div_pre;
                    end else begin
                        rep_q <= rep_q - REP_W'(1);
                    end
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end else begin
                div_q <= div_q + PSC_W'(1);
            end
        end
    end

    assign count      = cnt_q;
    assign update_evt = upd_q;

    // R4: the event pulse coincides with the count restarting at zero
    a_r4_evt_at_zero: assert property (@(posedge clk) disable iff (rst)
        update_evt |-> (count == '0));

    // R2: without a divided tick the count holds
    a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> $stable(count));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import pwm_dt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DT_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             pwm_mode,
    input  logic             tick,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp,
    input  logic [DT_W-1:0]  dt,
    input  logic             out_en,
    input  logic             brk,
    input  logic             idle_main,
    input  logic             idle_comp,
    output logic             out_main,
    output logic             out_comp
);

    logic            tog_q;
    logic            ref_w;
    logic            ref_q;
    logic [DT_W-1:0] gap_q;
    logic            raw_main;
    logic            raw_comp;
    logic            active;

    assign ref_w = run && (pwm_mode ? (count < cmp) : tog_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            tog_q <= 1'b0;
            ref_q <= 1'b0;
            gap_q <= '0;
        end else begin
            if (!run)
                tog_q <= 1'b0;
            else if (tick && (count == cmp))
                tog_q <= ~tog_q;

            if (ref_w != ref_q) begin
                ref_q <= ref_w;
                gap_q <= dt;
            end else if ((gap_q != '0) && (tick || !run)) begin
                gap_q <= gap_q - DT_W'(1);
            end
        end
    end

    assign raw_main = ref_q && (gap_q == '0);
    assign raw_comp = !ref_q && (gap_q == '0);
    assign active   = out_en && !brk;
    assign out_main = gated_out(active, raw_main, idle_main);
    assign out_comp = gated_out(active, raw_comp, idle_comp);

    // R8: brake forces idle levels in the same cycle
    a_r8_brake_idle: assert property (@(posedge clk) disable iff (rst)
        brk |-> (out_main == idle_main && out_comp == idle_comp));

    // R7: driven outputs never overlap
    a_r7_no_overlap: assert property (@(posedge clk) disable iff (rst)
        active |-> !(out_main && out_comp));

    // R7: a reference change with a nonzero guard opens a gap
    a_r7_gap_opens: assert property (@(posedge clk) disable iff (rst)
        ((ref_w != ref_q) && (dt != '0)) |=> !(raw_main || raw_comp));

    // R9: disabled outputs sit at idle levels
    a_r9_disabled_idle: assert property (@(posedge clk) disable iff (rst)
        !out_en |-> (out_main == idle_main && out_comp == idle_comp));

endmodule

// File: rtl/pwm_dt_timer.sv
module pwm_dt_timer
    import pwm_dt_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 16,
    parameter int REP_W  = 8,
    parameter int DT_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              brake_in,
    input  logic              clk_fail,
    output logic              out_main,
    output logic              out_comp,
    output logic              update_evt
);

    ctrl_t            ctrl;
    logic [PSC_W-1:0] div_pre;
    logic [CNT_W-1:0] period;
    logic [REP_W-1:0] rep_pre;
    logic [CNT_W-1:0] cmp;
    logic [DT_W-1:0]  dt;
    logic [CNT_W-1:0] count;
    logic             tick;
    logic             upd_fire;
    logic             brk;

    assign brk = brake_in | clk_fail;

    tmr_regs #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W),
        .REP_W(REP_W), .DT_W(DT_W)
    ) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .brk(brk), .upd_fire(upd_fire), .count(count),
        .ctrl(ctrl), .div_pre(div_pre), .period(period), .rep_pre(rep_pre),
        .cmp(cmp), .dt(dt), .rd_data(rd_data)
    );

    tmr_timebase #(
        .CNT_W(CNT_W), .PSC_W(PSC_W), .REP_W(REP_W)
    ) u_timebase (
        .clk(clk), .rst(rst), .run(ctrl.run),
        .div_pre(div_pre), .period(period), .rep_pre(rep_pre),
        .tick(tick), .upd_fire(upd_fire), .count(count),
        .update_evt(update_evt)
    );

    tmr_channel #(
        .CNT_W(CNT_W), .DT_W(DT_W)
    ) u_channel (
        .clk(clk), .rst(rst), .run(ctrl.run), .pwm_mode(ctrl.pwm_mode),
        .tick(tick), .count(count), .cmp(cmp), .dt(dt),
        .out_en(ctrl.out_en), .brk(brk),
        .idle_main(ctrl.idle_main), .idle_comp(ctrl.idle_comp),
        .out_main(out_main), .out_comp(out_comp)
    );

endmodule

// File: tb/pwm_dt_timer_tb.sv
module pwm_dt_timer_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = 3'd6;
    logic [15:0] rd_data;
    logic        brake_in = 1'b0;
    logic        clk_fail = 1'b0;
    logic        out_main, out_comp, update_evt;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    pwm_dt_timer u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .brake_in(brake_in), .clk_fail(clk_fail), .out_main(out_main),
        .out_comp(out_comp), .update_evt(update_evt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference state
    bit m_run, m_pwm, m_opm, m_oe, m_im, m_ic;
    int m_div, m_per, m_rep, m_cmp, m_dt;
    int div, cnt, rep, dact, gap;
    bit upd, tog, refq;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            {m_run, m_pwm, m_opm, m_oe, m_im, m_ic} = '0;
            m_div = 0; m_per = 0; m_rep = 0; m_cmp = 0; m_dt = 0;
            div = 0; cnt = 0; rep = 0; dact = 0; gap = 0;
            upd = 0; tog = 0; refq = 0;
        end else begin
            bit brk, tk, wrp, fire, rf;
            brk  = brake_in | clk_fail;
            tk   = m_run && (div == dact);
            wrp  = tk && (cnt >= m_per);
            fire = wrp && (rep == 0);
            rf   = m_run && (m_pwm ? (cnt < m_cmp) : tog);
            if (rf != refq) begin refq = rf; gap = m_dt; end
            else if (gap != 0 && (tk || !m_run)) gap--;
            if (!m_run) tog = 0;
            else if (tk && cnt == m_cmp) tog = !tog;
            upd = fire;
            if (!m_run) begin
                div = 0; cnt = 0; rep = m_rep; dact = m_div;
            end else if (tk) begin
                div = 0;
                if (wrp) begin
                    cnt = 0;
                    if (rep == 0) begin rep = m_rep; dact = m_div; end
                    else rep--;
                end else cnt++;
            end else div++;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: {m_ic, m_im, m_oe, m_opm, m_pwm, m_run} = wr_data[5:0];
                    3'd1: m_div = wr_data;
                    3'd2: m_per = wr_data;
                    3'd3: m_rep = wr_data[7:0];
                    3'd4: m_cmp = wr_data;
                    3'd5: m_dt  = wr_data[7:0];
                    default: ;
                endcase
            end
            if (brk) m_oe = 0;
            if (fire && m_opm) m_run = 0;
        end
    end

    function automatic int exp_rd(logic [2:0] a);
        case (a)
            3'd0: return {m_ic, m_im, m_oe, m_opm, m_pwm, m_run};
            3'd1: return m_div;
            3'd2: return m_per;
            3'd3: return m_rep;
            3'd4: return m_cmp;
            3'd5: return m_dt;
            3'd6: return cnt;
            default: return 0;
        endcase
    endfunction

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit act;
            act = m_oe && !(brake_in | clk_fail);
            chk("R4 update_evt", update_evt, upd);
            chk("R7 out_main", out_main, act ? (refq && gap == 0) : m_im);
            chk("R7 out_comp", out_comp, act ? (!refq && gap == 0) : m_ic);
            chk("R11 rd_data", rd_data, exp_rd(rd_addr));
        end
    end

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output int v);
        @(negedge clk); #1;
        rd_addr = a;
        @(negedge clk);
        v = rd_data;
    endtask

    task automatic wait_pulse(output int waited);
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!update_evt && waited < 2000);
    endtask

    task automatic spacing(output int s);
        int v0;
        int guard = 0;
        @(negedge clk);
        v0 = rd_data;
        while (rd_data == v0 && guard < 1000) begin @(negedge clk); guard++; end
        v0 = rd_data;
        s = 0;
        do begin
            @(negedge clk);
            s++;
        end while (rd_data == v0 && s < 1000);
    endtask

    task automatic highs(int n, output int hm, output int hc);
        hm = 0; hc = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #2;
            if (out_main) hm++;
            if (out_comp) hc++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int v, w, hm, hc, mx;
        repeat (4) @(negedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 out_main", out_main, 0);
        chk("R1 out_comp", out_comp, 0);
        chk("R1 update_evt", update_evt, 0);
        chk("R1 count", rd_data, 0);

        wr(3'd1, 2); wr(3'd2, 4); wr(3'd3, 1); wr(3'd4, 2); wr(3'd5, 1);
        wr(3'd0, 16'h000B);
        spacing(v);
        chk("R2 tick spacing", v, 3);
        mx = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (rd_data > mx) mx = rd_data;
        end
        chk("R3 max count", mx, 4);
        wait_pulse(w); wait_pulse(w);
        chk("R4 event interval", w, 30);

        // R5 buffered divider and repetition
        wr(3'd1, 0); wr(3'd3, 0);
        spacing(v);
        chk("R5 old divider kept", v, 3);
        wait_pulse(w); wait_pulse(w);
        chk("R5 new interval", w, 5);

        // R6 / R7 waveform shapes
        wr(3'd0, 0); wr(3'd2, 9); wr(3'd4, 3); wr(3'd5, 0);
        wr(3'd0, 16'h000B);
        repeat (30) @(negedge clk);
        highs(10, hm, hc);
        chk("R6 pwm main highs", hm, 3);
        chk("R6 pwm comp highs", hc, 7);
        wr(3'd5, 2);
        repeat (30) @(negedge clk);
        highs(10, hm, hc);
        chk("R7 dead main highs", hm, 1);
        chk("R7 dead comp highs", hc, 5);
        wr(3'd5, 0); wr(3'd0, 16'h0009);
        repeat (30) @(negedge clk);
        highs(20, hm, hc);
        chk("R6 compare main highs", hm, 10);

        // R8 / R9 brake and re-arm
        wr(3'd0, 16'h001B);
        repeat (5) @(negedge clk);
        #1 brake_in = 1'b1;
        #1;
        chk("R8 brake main idle", out_main, 1);
        chk("R8 brake comp idle", out_comp, 0);
        repeat (3) @(negedge clk);
        #1 brake_in = 1'b0;
        repeat (5) @(negedge clk);
        #2;
        chk("R9 held main idle", out_main, 1);
        chk("R9 held comp idle", out_comp, 0);
        rd(3'd0, v);
        chk("R9 enable bit cleared", (v >> 3) & 1, 0);
        @(negedge clk); #1 rd_addr = 3'd6;
        wr(3'd0, 16'h000B);
        repeat (30) @(negedge clk);
        highs(10, hm, hc);
        chk("R9 rearmed main highs", hm, 3);
        @(negedge clk); #1 clk_fail = 1'b1;
        #1;
        chk("R8 clk_fail main", out_main, 0);
        chk("R8 clk_fail comp", out_comp, 0);
        @(negedge clk); #1 clk_fail = 1'b0;
        rd(3'd0, v);
        chk("R8 clk_fail clears enable", (v >> 3) & 1, 0);

        // R10 one-pulse
        wr(3'd0, 0); wr(3'd2, 5); wr(3'd3, 0); wr(3'd1, 0);
        wr(3'd0, 16'h000F);
        wait_pulse(w);
        repeat (3) @(negedge clk);
        rd(3'd0, v);
        chk("R10 run cleared", v & 1, 0);
        rd(3'd6, v);
        chk("R10 count parked", v, 0);

        // R11 readback
        wr(3'd4, 16'h1234);
        rd(3'd4, v);
        chk("R11 cmp readback", v, 16'h1234);
        rd(3'd7, v);
        chk("R11 unused address", v, 0);

        repeat (4) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule